// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a small programmable sum-of-products device. It takes a set of product terms from an external AND array and ORs them into a sum. A polarity bit can invert the sum. The result reaches a tri-state pin driver either directly or through a D register. The cell also returns a feedback signal to the AND array through a multiplexer whose source depends on the mode.

Two device-wide architecture bits and one per-cell bit choose between these modes:

- a registered output;
- a dedicated combinational output;
- a combinational I/O whose last product term acts as the driver enable, in two variants;
- a pure input.

A cell-position parameter marks the cell as one of three classes. An end cell can take its feedback from the clock or enable pin when those pins are free. A middle cell has no feedback as a dedicated output. The remaining cells are ordinary.

The pad is modelled without a bidirectional port. `pin_o` and `pin_oe_o` describe the driver, and `pin_ext_i` is the value an outside source puts on the pad while the driver is off.

Top module: `pld_macrocell`

## Requirements
- R1: Registered mode ({arch_a_i,arch_b_i,cell_io_i} = 3'b010) ORs all product terms. After polarity it stores the result on each rising clk_i edge. `pin_o` shows the stored value while the driver is on. An active-low asynchronous rst_ni clears the stored value to 0.
- R2: In registered mode the driver enable is the inverse of the active-low oe_ni, and fb_o is the stored register value for every cell class.
- R3: With pol_hi_i = 1 the sum is passed unchanged; with pol_hi_i = 0 it is inverted. Inversion happens before the register and the driver.
- R4: Dedicated output mode (3'b100) ORs all product terms and keeps the driver on at all times.
- R5: Both combinational I/O modes (3'b111 and 3'b011) OR only product terms 0 to PT_NUM-2. The top product term, index PT_NUM-1, is the driver enable.
- R6: In the two combinational I/O modes, fb_o is the pad value: `pin_o` when the driver is on, otherwise pin_ext_i. The exception is an end cell in mode 3'b111, which returns ded_pin_i.
- R7: Input mode (3'b101) keeps the driver off. fb_o is ded_pin_i for end cells and adj_pin_i for all other cells.
- R8: In dedicated output mode, fb_o is ded_pin_i for end cells, 0 for middle cells and adj_pin_i for other cells.
- R9: Codes 3'b000, 3'b001 and 3'b110 are reserved. They keep the driver off and force fb_o to 0.
- R10: Whenever the driver is off, pin_o is 0.
- R11: End cells are CELL_IDX 0 and CELL_CNT-1. Middle cells are CELL_IDX CELL_CNT/2-1 and CELL_CNT/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the register |
| pt_i | input | PT_NUM | Product terms from the AND array |
| arch_a_i | input | 1 | Device-wide architecture bit A |
| arch_b_i | input | 1 | Device-wide architecture bit B |
| cell_io_i | input | 1 | Per-cell mode bit |
| pol_hi_i | input | 1 | Per-cell polarity, 1 = active high |
| oe_ni | input | 1 | Active-low output-enable pin |
| pin_ext_i | input | 1 | Externally driven pad value |
| adj_pin_i | input | 1 | Pad value of the neighbouring cell |
| ded_pin_i | input | 1 | Clock or enable pin used as an input, for end cells |
| pin_o | output | 1 | Driven pad value |
| pin_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback to the AND array |

## Verification
The bench builds three copies with PT_NUM = 8 and CELL_CNT = 8, using CELL_IDX values 0, 3 and 5. One copy is an end cell, one a middle cell and one an ordinary cell, so every branch of the feedback multiplexer can be reached. All eight control codes, both polarities, all 256 product-term vectors and every combination of oe_ni, pin_ext_i, adj_pin_i and ded_pin_i are swept. Together these cover the reserved codes, the product-term enable, and capture into the register on each edge.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  typedef enum logic [2:0] {
    MC_REG,
    MC_COM_OUT,
    MC_COM_IO,
    MC_COM_IO_R,
    MC_IN,
    MC_RSVD
  } mc_mode_e;

  typedef enum logic [1:0] {
    CK_STD,
    CK_END,
    CK_MID
  } cell_kind_e;

  function automatic cell_kind_e cell_kind(input int idx, input int cnt);
    if (idx == 0 || idx == cnt - 1)
      return CK_END;
    if (idx == cnt / 2 - 1 || idx == cnt / 2)
      return CK_MID;
    return CK_STD;
  endfunction

endpackage

// File: rtl/mc_mode_dec.sv
module mc_mode_dec
  import pld_mc_pkg::*;
(
  input  logic     arch_a_i,
  input  logic     arch_b_i,
  input  logic     cell_io_i,
  output mc_mode_e mode_o
);

  always_comb begin
    unique case ({arch_a_i, arch_b_i, cell_io_i})
      3'b010:  mode_o = MC_REG;
      3'b100:  mode_o = MC_COM_OUT;
      3'b111:  mode_o = MC_COM_IO;
      3'b011:  mode_o = MC_COM_IO_R;
      3'b101:  mode_o = MC_IN;
      default: mode_o = MC_RSVD;
    endcase
  end

endmodule

// File: rtl/mc_sum.sv
module mc_sum
  import pld_mc_pkg::*;
#(
  parameter int PT_NUM = 8
) (
  input  logic [PT_NUM-1:0] pt_i,
  input  mc_mode_e          mode_i,
  input  logic              pol_hi_i,
  output logic              d_o
);

  localparam int LAST = PT_NUM - 1;

  logic io_mode;
  logic sum;

  assign io_mode = (mode_i == MC_COM_IO) || (mode_i == MC_COM_IO_R);

  // top term is withheld from the OR in the I/O modes (it drives the enable)
  always_comb begin
    sum = 1'b0;
    for (int i = 0; i < LAST; i++)
      sum = sum | pt_i[i];
    sum = sum | (pt_i[LAST] & ~io_mode);
  end

  assign d_o = pol_hi_i ? sum : ~sum;

endmodule

// File: rtl/mc_fb_mux.sv
module mc_fb_mux
  import pld_mc_pkg::*;
#(
  parameter cell_kind_e KIND = CK_STD
) (
  input  mc_mode_e mode_i,
  input  logic     arch_a_i,
  input  logic     arch_b_i,
  input  logic     q_i,
  input  logic     pad_i,
  input  logic     adj_i,
  input  logic     ded_i,
  output logic     fb_o
);

  logic own;

  assign own = (mode_i == MC_REG) ? q_i : pad_i;

  always_comb begin
    fb_o = 1'b0;
    if (mode_i != MC_RSVD) begin
      if (KIND == CK_END) begin
        // end cells: bit A steers between the free dedicated pin and the own path
        fb_o = arch_a_i ? ded_i : own;
      end else if (arch_b_i) begin
        fb_o = own;
      end else if (KIND == CK_MID && mode_i == MC_COM_OUT) begin
        fb_o = 1'b0;
      end else begin
        fb_o = adj_i;
      end
    end
  end

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int PT_NUM   = 8,
  parameter int CELL_CNT = 8,
  parameter int CELL_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PT_NUM-1:0] pt_i,
  input  logic              arch_a_i,
  input  logic              arch_b_i,
  input  logic              cell_io_i,
  input  logic              pol_hi_i,
  input  logic              oe_ni,
  input  logic              pin_ext_i,
  input  logic              adj_pin_i,
  input  logic              ded_pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              fb_o
);

  localparam cell_kind_e KIND = cell_kind(CELL_IDX, CELL_CNT);

  mc_mode_e mode;
  logic     d;
  logic     q_q;
  logic     val;
  logic     pad;

  mc_mode_dec u_dec (
    .arch_a_i  (arch_a_i),
    .arch_b_i  (arch_b_i),
    .cell_io_i (cell_io_i),
    .mode_o    (mode)
  );

  mc_sum #(.PT_NUM(PT_NUM)) u_sum (
    .pt_i     (pt_i),
    .mode_i   (mode),
    .pol_hi_i (pol_hi_i),
    .d_o      (d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= d;
  end

  always_comb begin
    unique case (mode)
      MC_REG:                pin_oe_o = ~oe_ni;
      MC_COM_OUT:            pin_oe_o = 1'b1;
      MC_COM_IO, MC_COM_IO_R: pin_oe_o = pt_i[PT_NUM-1];
      default:               pin_oe_o = 1'b0;
    endcase
  end

  assign val   = (mode == MC_REG) ? q_q : d;
  assign pin_o = pin_oe_o & val;
  assign pad   = pin_oe_o ? pin_o : pin_ext_i;

  mc_fb_mux #(.KIND(KIND)) u_fb (
    .mode_i   (mode),
    .arch_a_i (arch_a_i),
    .arch_b_i (arch_b_i),
    .q_i      (q_q),
    .pad_i    (pad),
    .adj_i    (adj_pin_i),
    .ded_i    (ded_pin_i),
    .fb_o     (fb_o)
  );

  AST_REG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (q_q == $past(d))); // R1

  AST_REG_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MC_REG) |-> (pin_oe_o == !oe_ni && fb_o == q_q)); // R2

  AST_PT_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MC_COM_IO || mode == MC_COM_IO_R) |-> (pin_oe_o == pt_i[PT_NUM-1])); // R5

  AST_INPUT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MC_IN) |-> !pin_oe_o); // R7

  AST_RSVD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MC_RSVD) |-> (!pin_oe_o && !fb_o)); // R9

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o); // R10

  generate
    if (KIND == CK_MID) begin : g_mid_chk
      AST_MID_NO_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MC_COM_OUT) |-> !fb_o); // R8
    end
  endgenerate

endmodule

// File: tb/pld_macrocell_tb_top.sv
module pld_macrocell_tb_top;

  localparam int PT_NUM   = 8;
  localparam int CELL_CNT = 8;
  localparam int NCELL    = 3;

  logic              clk;
  logic              rst_n;
  logic [PT_NUM-1:0] pt;
  logic              arch_a, arch_b, cell_io, pol_hi, oe_n, ext, adj, ded;
  logic [NCELL-1:0]  pin, pin_oe, fb;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int cell_of(input int k);
    return (k == 0) ? 0 : (k == 1) ? 3 : 5;
  endfunction

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    pld_macrocell #(
      .PT_NUM  (PT_NUM),
      .CELL_CNT(CELL_CNT),
      .CELL_IDX(cell_of(k))
    ) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .pt_i      (pt),
      .arch_a_i  (arch_a),
      .arch_b_i  (arch_b),
      .cell_io_i (cell_io),
      .pol_hi_i  (pol_hi),
      .oe_ni     (oe_n),
      .pin_ext_i (ext),
      .adj_pin_i (adj),
      .ded_pin_i (ded),
      .pin_o     (pin[k]),
      .pin_oe_o  (pin_oe[k]),
      .fb_o      (fb[k])
    );
  end

  // returns {pin, oe, fb}
  function automatic logic [2:0] ref_fn(input int idx, input logic [2:0] code,
                                        input logic pl, input logic [PT_NUM-1:0] p,
                                        input logic oen, input logic ex,
                                        input logic ad, input logic dd);
    logic is_end, is_mid, s8, s7, v, o, pv, f;
    is_end = (idx == 0) || (idx == CELL_CNT - 1);
    is_mid = (idx == CELL_CNT/2 - 1) || (idx == CELL_CNT/2);
    s8 = |p;
    s7 = |p[PT_NUM-2:0];
    v = 1'b0; o = 1'b0; f = 1'b0;
    case (code)
      3'b010: begin v = pl ? s8 : ~s8; o = ~oen; f = v; end
      3'b100: begin
        v = pl ? s8 : ~s8; o = 1'b1;
        f = is_end ? dd : (is_mid ? 1'b0 : ad);
      end
      3'b111, 3'b011: begin
        v = pl ? s7 : ~s7; o = p[PT_NUM-1];
        pv = o ? v : ex;
        f = (is_end && code == 3'b111) ? dd : pv;
      end
      3'b101: begin o = 1'b0; f = is_end ? dd : ad; end
      default: begin o = 1'b0; f = 1'b0; end
    endcase
    return {o & v, o, f};
  endfunction

  function automatic string req_of(input logic [2:0] code, input int idx);
    case (code)
      3'b010:         return "R1/R2/R3";
      3'b100:         return (idx == 3) ? "R4/R8/R11" : "R4/R8";
      3'b111, 3'b011: return "R5/R6";
      3'b101:         return "R7";
      default:        return "R9/R10";
    endcase
  endfunction

  task automatic check_all(input logic [2:0] code);
    for (int k = 0; k < NCELL; k++) begin
      logic [2:0] exp, act;
      exp = ref_fn(cell_of(k), code, pol_hi, pt, oe_n, ext, adj, ded);
      act = {pin[k], pin_oe[k], fb[k]};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s cell %0d code %b pol %b pt %h: {pin,oe,fb} act %b exp %b",
                 req_of(code, cell_of(k)), cell_of(k), code, pol_hi, pt, act, exp);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    pt = '1; {arch_a, arch_b, cell_io} = 3'b010; pol_hi = 1'b1;
    oe_n = 1'b0; ext = 1'b0; adj = 1'b0; ded = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: register held cleared in reset, driver on, fb shows cleared value
    for (int k = 0; k < NCELL; k++) begin
      checks++;
      if ({pin[k], pin_oe[k], fb[k]} !== 3'b010) begin
        errors++;
        $display("FAIL R1 reset cell %0d: act %b exp 010", cell_of(k),
                 {pin[k], pin_oe[k], fb[k]});
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) begin
      for (int pl = 0; pl < 2; pl++) begin
        for (int p = 0; p < 256; p++) begin
          for (int m = 0; m < 16; m++) begin
            @(negedge clk);
            {arch_a, arch_b, cell_io} = 3'(c);
            pol_hi = 1'(pl);
            pt = 8'(p);
            {oe_n, ext, adj, ded} = 4'(m);
            @(posedge clk);
            #1;
            check_all(3'(c));
          end
        end
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule